// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous, idle-high serial line into bytes. A programmable divider makes a sampling tick at sixteen times the bit rate. The receiver waits for the line to fall, which marks a start bit. It then takes three samples near the centre of every bit and decides each bit by majority vote. It shifts in a frame of 10 bits, or 11 bits when the nine-bit mode is on, and removes the start and stop bits. The byte goes to a read-only data register. In nine-bit mode the extra bit goes to a separate status output.

Software services the block through two strobes: a status read and a data read. A flag clears only when a status read saw it set and a data read follows that status read. A frame that finishes while the data register still holds an unread byte is kept back. It enters the data register when software completes the clearing sequence. If yet another frame starts while a frame is kept back, the overrun flag is raised and that newest frame is discarded. An idle-line flag reports one full frame time of continuous marking after a frame. Two separate enables gate the data-full and idle conditions onto a single interrupt request.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the data output, every flag and the interrupt request are 0. A frame begins only on a high-to-low transition of the line. A start bit whose majority vote reads 1 is dropped, and no byte is delivered.
- R2: One sampling tick occurs every baud_div+1 clocks, and one bit lasts 16 ticks. A bit's value is the majority of the samples at ticks 7, 8 and 9 after the bit edge. Data bits arrive least significant first, and rx_data[0] is the first data bit received.
- R3: If the three samples of any bit in a frame disagree, noise_flag is set when that frame's byte is loaded. The majority value is still delivered.
- R4: If the stop bit votes 0, frm_flag is set when that frame's byte is loaded. The byte is still delivered.
- R5: With nine_bit at 0 a frame carries 8 data bits and rx_bit8 is loaded as 0. With nine_bit at 1 the ninth received data bit goes to rx_bit8 and rx_data carries the first eight.
- R6: full_flag is set when a byte is loaded. It clears only on a data_rd pulse that follows a stat_rd pulse that observed full_flag at 1. A data_rd without such a status read, or after a status read that saw the flag at 0, leaves it set. The same rule clears idle_flag, ovr_flag, noise_flag and frm_flag.
- R7: A frame that completes while full_flag is set does not change rx_data. It is loaded when the clearing sequence completes, and full_flag stays set.
- R8: A start bit confirmed while a completed frame is held back sets ovr_flag. The data of that newest frame is never delivered.
- R9: idle_flag is set after 16 x frame-length ticks of continuous high line following a received frame. Frame length is 10 bits, or 11 in nine-bit mode. It is not set again until another frame has been received.
- R10: irq is 1 exactly when (rx_irq_en and full_flag) or (idle_irq_en and idle_flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| baud_div | input | DIV_W | Tick divider; tick period is baud_div+1 clocks |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| rx_irq_en | input | 1 | Lets full_flag drive irq |
| idle_irq_en | input | 1 | Lets idle_flag drive irq |
| stat_rd | input | 1 | Status read strobe; arms the clearing of the flags set at that moment |
| data_rd | input | 1 | Data read strobe; clears the armed flags |
| rx_data | output | 8 | Data register |
| rx_bit8 | output | 1 | Ninth data bit of the loaded frame |
| full_flag | output | 1 | Data register holds an unread byte |
| idle_flag | output | 1 | Line idle for a frame time after a frame |
| ovr_flag | output | 1 | A frame was lost |
| noise_flag | output | 1 | Sample disagreement in the loaded frame |
| frm_flag | output | 1 | Stop bit of the loaded frame read as 0 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the overrun. One byte must sit unread in the data register, a second completed frame must be held back, and a third start bit must arrive before software acts. The bench sends three frames back to back with no read between them. It then runs two clearing sequences to show that the held frame appears and the third frame is gone. Noise needs exactly one of the three centre samples to be corrupted. With the divider at zero, every clock is a tick, so the bench inverts the line for one clock at the eighth clock of a chosen bit. Random frames at several divider settings and in both modes cover the ordinary path.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int OVS       = 16;
    localparam int DATA_BITS = 8;
    localparam int FRAME_MAX = DATA_BITS + 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_phase_e;

    typedef struct packed {
        logic [DATA_BITS:0] data;
        logic               noise;
        logic               frm;
    } rx_frame_t;

    typedef struct packed {
        logic full;
        logic idle;
        logic ovr;
        logic noise;
        logic frm;
    } rx_flags_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_shifter.sv
module serial_rx_shifter
    import serial_rx_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      nine_bit,
    output logic      start_ok,
    output logic      frame_done,
    output rx_frame_t frame
);

    localparam int PH_W = $clog2(OVS_N);
    localparam int MID  = OVS_N / 2;
    localparam logic [PH_W-1:0] S_LO    = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] S_MD    = PH_W'(MID);
    localparam logic [PH_W-1:0] S_HI    = PH_W'(MID + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS_N - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    rx_phase_e          st;
    logic [PH_W-1:0]    ph;
    logic [3:0]         bidx;
    logic [1:0]         early;
    logic [DATA_BITS:0] sh;
    logic               nacc;
    logic               last;
    logic               vote;
    logic               split;
    logic               last_bit;

    assign vote     = maj3(early[0], early[1], line);
    assign split    = split3(early[0], early[1], line);
    assign last_bit = (bidx == (nine_bit ? 4'(DATA_BITS) : 4'(DATA_BITS - 1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= '0;
            bidx       <= '0;
            early      <= '0;
            sh         <= '0;
            nacc       <= 1'b0;
            last       <= 1'b1;
            start_ok   <= 1'b0;
            frame_done <= 1'b0;
            frame      <= '0;
        end else begin
            start_ok   <= 1'b0;
            frame_done <= 1'b0;
            if (tick) begin
                last <= line;
                if (st == ST_IDLE) begin
                    if (last && !line) begin
                        st   <= ST_START;
                        ph   <= PH_ONE;
                        bidx <= '0;
                        sh   <= '0;
                        nacc <= 1'b0;
                    end
                end else begin
                    ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
                    if (ph == S_LO) begin
                        early[0] <= line;
                    end
                    if (ph == S_MD) begin
                        early[1] <= line;
                    end
                    if (ph == S_HI) begin
                        case (st)
                            ST_START: begin
                                if (vote) begin
                                    st <= ST_IDLE;
                                end else begin
                                    start_ok <= 1'b1;
                                    nacc     <= split;
                                end
                            end
                            ST_DATA: begin
                                sh[bidx] <= vote;
                                nacc     <= nacc | split;
                            end
                            ST_STOP: begin
                                frame_done  <= 1'b1;
                                frame.data  <= sh;
                                frame.noise <= nacc | split;
                                frame.frm   <= !vote;
                                st          <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (ph == PH_LAST) begin
                        case (st)
                            ST_START: begin
                                st   <= ST_DATA;
                                bidx <= '0;
                            end
                            ST_DATA: begin
                                if (last_bit) begin
                                    st <= ST_STOP;
                                end else begin
                                    bidx <= bidx + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/serial_rx_idle.sv
module serial_rx_idle
    import serial_rx_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    input  logic nine_bit,
    input  logic frame_done,
    output logic idle_evt
);

    localparam int MAXT = OVS_N * FRAME_MAX;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LIM_LONG  = CW'(OVS_N * FRAME_MAX - 1);
    localparam logic [CW-1:0] LIM_SHORT = CW'(OVS_N * (FRAME_MAX - 1) - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          armed;

    assign limit = nine_bit ? LIM_LONG : LIM_SHORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (frame_done) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && tick) begin
                if (!line) begin
                    cnt <= '0;
                end else if (cnt >= limit) begin
                    idle_evt <= 1'b1;
                    armed    <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int OVS_N = OVS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             nine_bit,
    input  logic             rx_irq_en,
    input  logic             idle_irq_en,
    input  logic             stat_rd,
    input  logic             data_rd,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             full_flag,
    output logic             idle_flag,
    output logic             ovr_flag,
    output logic             noise_flag,
    output logic             frm_flag,
    output logic             irq
);

    logic      tick;
    logic      line;
    logic      start_ok;
    logic      frame_done;
    logic      idle_evt;
    rx_frame_t frame;

    serial_rx_tick #(.DIV_W(DIV_W)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .div  (baud_div),
        .tick (tick)
    );

    serial_rx_sync #(.STAGES(2)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line)
    );

    serial_rx_shifter #(.OVS_N(OVS_N)) shift_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .line       (line),
        .nine_bit   (nine_bit),
        .start_ok   (start_ok),
        .frame_done (frame_done),
        .frame      (frame)
    );

    serial_rx_idle #(.OVS_N(OVS_N)) idle_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .line       (line),
        .nine_bit   (nine_bit),
        .frame_done (frame_done),
        .idle_evt   (idle_evt)
    );

    rx_flags_t          flg;
    rx_flags_t          arm;
    rx_flags_t          clr;
    rx_frame_t          pend;
    rx_frame_t          ld_frame;
    logic               pend_v;
    logic               discard;
    logic [DATA_BITS:0] dat;
    logic               release_p;
    logic               full_after;
    logic               ovr_evt;
    logic               keep_new;
    logic               load_new;
    logic               stash_new;
    logic               load_any;

    assign clr        = data_rd ? arm : '0;
    assign release_p  = clr.full && pend_v;
    assign full_after = flg.full && !clr.full;
    assign ovr_evt    = start_ok && pend_v && !release_p;
    assign keep_new   = frame_done && !discard;
    assign load_new   = keep_new && !full_after && !pend_v;
    assign stash_new  = keep_new && !load_new;
    assign load_any   = release_p || load_new;
    assign ld_frame   = release_p ? pend : frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            flg     <= '0;
            arm     <= '0;
            pend    <= '0;
            pend_v  <= 1'b0;
            discard <= 1'b0;
            dat     <= '0;
        end else begin
            if (load_any) begin
                dat <= ld_frame.data;
            end
            if (stash_new) begin
                pend   <= frame;
                pend_v <= 1'b1;
            end else if (release_p) begin
                pend_v <= 1'b0;
            end
            if (ovr_evt) begin
                discard <= 1'b1;
            end else if (frame_done) begin
                discard <= 1'b0;
            end
            flg.full  <= load_any | full_after;
            flg.noise <= load_any ? ld_frame.noise : (flg.noise & ~clr.noise);
            flg.frm   <= load_any ? ld_frame.frm : (flg.frm & ~clr.frm);
            flg.ovr   <= ovr_evt | (flg.ovr & ~clr.ovr);
            flg.idle  <= idle_evt | (flg.idle & ~clr.idle);
            if (stat_rd) begin
                arm <= flg;
            end else if (data_rd) begin
                arm <= '0;
            end
        end
    end

    assign rx_data    = dat[DATA_BITS-1:0];
    assign rx_bit8    = dat[DATA_BITS];
    assign full_flag  = flg.full;
    assign idle_flag  = flg.idle;
    assign ovr_flag   = flg.ovr;
    assign noise_flag = flg.noise;
    assign frm_flag   = flg.frm;
    assign irq        = (rx_irq_en & flg.full) | (idle_irq_en & flg.idle);

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       data_rd,
    input logic       rx_irq_en,
    input logic       idle_irq_en,
    input logic [7:0] rx_data,
    input logic       full_flag,
    input logic       idle_flag,
    input logic       ovr_flag,
    input logic       frm_flag,
    input logic       irq
);

    assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (!full_flag && !idle_flag) |-> !irq);

    assert_rx_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_irq_en && full_flag) |-> irq);

    assert_idle_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (idle_irq_en && idle_flag) |-> irq);

    assert_full_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(full_flag) |-> $past(data_rd));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> full_flag);

    assert_ovr_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(full_flag));

    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_flag) |-> $past(data_rd));

    assert_frm_with_byte_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_flag) |-> full_flag);

endmodule

bind serial_rx_core serial_rx_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .data_rd     (data_rd),
    .rx_irq_en   (rx_irq_en),
    .idle_irq_en (idle_irq_en),
    .rx_data     (rx_data),
    .full_flag   (full_flag),
    .idle_flag   (idle_flag),
    .ovr_flag    (ovr_flag),
    .frm_flag    (frm_flag),
    .irq         (irq)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic [11:0] baud_div = '0;
    logic        nine_bit = 1'b0;
    logic        rx_irq_en = 1'b0;
    logic        idle_irq_en = 1'b0;
    logic        stat_rd = 1'b0;
    logic        data_rd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_bit8;
    logic        full_flag;
    logic        idle_flag;
    logic        ovr_flag;
    logic        noise_flag;
    logic        frm_flag;
    logic        irq;

    int vec_n = 0;
    int bad_n = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    serial_rx_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .rxd         (rxd),
        .baud_div    (baud_div),
        .nine_bit    (nine_bit),
        .rx_irq_en   (rx_irq_en),
        .idle_irq_en (idle_irq_en),
        .stat_rd     (stat_rd),
        .data_rd     (data_rd),
        .rx_data     (rx_data),
        .rx_bit8     (rx_bit8),
        .full_flag   (full_flag),
        .idle_flag   (idle_flag),
        .ovr_flag    (ovr_flag),
        .noise_flag  (noise_flag),
        .frm_flag    (frm_flag),
        .irq         (irq)
    );

    function automatic int exp_byte(input logic [8:0] d);
        return int'(d[7:0]);
    endfunction

    function automatic int exp_b8(input logic [8:0] d, input bit nine);
        return nine ? int'(d[8]) : 0;
    endfunction

    function automatic int exp_irq(input bit rie, input bit iie, input bit f, input bit i);
        return int'((rie && f) || (iie && i));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vec_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
            $finish;
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input bit nine, input bit stopv,
                              input int glitch_bit, input int cpb);
        int nb;
        nb = nine ? 11 : 10;
        for (int b = 0; b < nb; b++) begin
            logic v;
            if (b == 0) v = 1'b0;
            else if (b == nb - 1) v = stopv;
            else v = d[b-1];
            for (int c = 0; c < cpb; c++) begin
                @(negedge clk);
                rxd = v ^ ((b == glitch_bit) && (c == 8));
            end
        end
        @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic pulse_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic read_seq();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        vec_n++;
        bad_n++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset rx_data", int'(rx_data), 0);
        chk("R1 reset full", int'(full_flag), 0);
        chk("R1 reset idle", int'(idle_flag), 0);
        chk("R1 reset ovr", int'(ovr_flag), 0);
        chk("R1 reset noise", int'(noise_flag), 0);
        chk("R1 reset frm", int'(frm_flag), 0);
        chk("R1 reset irq", int'(irq), 0);

        // R1 false start: short low pulse, majority of centre samples is high
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        chk("R1 false start no byte", int'(full_flag), 0);

        // R2 basic 8-bit frame, divider 0
        send_frame(9'h0A5, 1'b0, 1'b1, -1, 16);
        repeat (4) @(negedge clk);
        chk("R2 byte A5", int'(rx_data), exp_byte(9'h0A5));
        chk("R6 full set", int'(full_flag), 1);
        chk("R3 clean noise", int'(noise_flag), 0);
        chk("R4 clean frm", int'(frm_flag), 0);
        chk("R10 irq masked", int'(irq), 0);
        rx_irq_en = 1'b1;
        @(negedge clk);
        chk("R10 irq rx enabled", int'(irq), exp_irq(1, 0, full_flag, idle_flag));
        chk("R10 irq rx value", int'(irq), 1);
        rx_irq_en = 1'b0;

        // R6 data read alone does not clear
        pulse_data();
        chk("R6 data read alone", int'(full_flag), 1);
        read_seq();
        chk("R6 sequence clears full", int'(full_flag), 0);
        chk("R6 data kept after read", int'(rx_data), 8'hA5);

        // R6 status read that saw full=0 does not arm clearing
        pulse_stat();
        send_frame(9'h03C, 1'b0, 1'b1, -1, 16);
        repeat (4) @(negedge clk);
        pulse_data();
        chk("R6 stale status read", int'(full_flag), 1);
        chk("R2 byte 3C", int'(rx_data), 8'h3C);
        read_seq();
        chk("R6 cleared after fresh sequence", int'(full_flag), 0);

        // R3 noise: one centre sample of data bit 3 inverted
        send_frame(9'h05A, 1'b0, 1'b1, 4, 16);
        repeat (4) @(negedge clk);
        chk("R3 byte survives glitch", int'(rx_data), 8'h5A);
        chk("R3 noise set", int'(noise_flag), 1);
        read_seq();
        chk("R3 noise cleared", int'(noise_flag), 0);

        // R4 framing error
        send_frame(9'h081, 1'b0, 1'b0, -1, 16);
        repeat (40) @(negedge clk);
        chk("R4 frm set", int'(frm_flag), 1);
        chk("R4 byte delivered", int'(rx_data), 8'h81);
        read_seq();
        chk("R4 frm cleared", int'(frm_flag), 0);

        // R5 nine-bit mode
        nine_bit = 1'b1;
        send_frame(9'h1C3, 1'b1, 1'b1, -1, 16);
        repeat (4) @(negedge clk);
        chk("R5 nine-bit data", int'(rx_data), exp_byte(9'h1C3));
        chk("R5 nine-bit bit8 one", int'(rx_bit8), exp_b8(9'h1C3, 1'b1));
        read_seq();
        send_frame(9'h0F0, 1'b1, 1'b1, -1, 16);
        repeat (4) @(negedge clk);
        chk("R5 nine-bit bit8 zero", int'(rx_bit8), 0);
        chk("R5 nine-bit data F0", int'(rx_data), 8'hF0);
        read_seq();
        nine_bit = 1'b0;

        // R9 idle flag timing (expected near 158 clocks after the frame ends)
        send_frame(9'h011, 1'b0, 1'b1, -1, 16);
        chk("R9 idle clear at frame end", int'(idle_flag), 0);
        repeat (125) @(negedge clk);
        chk("R9 idle not yet", int'(idle_flag), 0);
        repeat (40) @(negedge clk);
        chk("R9 idle set", int'(idle_flag), 1);
        idle_irq_en = 1'b1;
        @(negedge clk);
        chk("R10 irq idle", int'(irq), exp_irq(0, 1, full_flag, idle_flag));
        idle_irq_en = 1'b0;
        read_seq();
        chk("R9 idle cleared", int'(idle_flag), 0);
        chk("R6 full cleared with idle", int'(full_flag), 0);
        repeat (400) @(negedge clk);
        chk("R9 idle not set again", int'(idle_flag), 0);

        // R7 and R8: hold-back and overrun
        send_frame(9'h021, 1'b0, 1'b1, -1, 16);
        send_frame(9'h042, 1'b0, 1'b1, -1, 16);
        repeat (4) @(negedge clk);
        chk("R7 first byte held", int'(rx_data), 8'h21);
        chk("R7 no overrun yet", int'(ovr_flag), 0);
        send_frame(9'h063, 1'b0, 1'b1, -1, 16);
        repeat (4) @(negedge clk);
        chk("R8 overrun set", int'(ovr_flag), 1);
        chk("R8 data unchanged", int'(rx_data), 8'h21);
        read_seq();
        chk("R7 held byte released", int'(rx_data), 8'h42);
        chk("R7 full stays set", int'(full_flag), 1);
        chk("R8 overrun cleared", int'(ovr_flag), 0);
        read_seq();
        chk("R8 third frame lost full", int'(full_flag), 0);
        chk("R8 third frame lost data", int'(rx_data), 8'h42);

        // R2 R5 R4 random frames at several dividers
        for (int i = 0; i < 30; i++) begin
            logic [8:0] d;
            bit nine;
            bit stopv;
            int dv;
            dv = int'($urandom_range(0, 3));
            nine = bit'($urandom_range(0, 1));
            stopv = ($urandom_range(0, 7) != 0);
            d = 9'($urandom);
            baud_div = 12'(dv);
            nine_bit = nine;
            repeat (20) @(negedge clk);
            send_frame(d, nine, stopv, -1, 16 * (dv + 1));
            repeat (4) @(negedge clk);
            chk("R2 random data", int'(rx_data), exp_byte(d));
            chk("R5 random bit8", int'(rx_bit8), exp_b8(d, nine));
            chk("R4 random frm", int'(frm_flag), int'(!stopv));
            chk("R3 random noise", int'(noise_flag), 0);
            read_seq();
            chk("R6 random cleared", int'(full_flag), 0);
        end

        finish_run();
    end

endmodule